// File: doc/BRIEF.md
# Command Replay Buffer with Oldest-Word Eviction

This block stores a single multi-word command as a ring of 32-bit words. Software loads the command one word per push strobe. A sequencer then streams the command out one word per pop strobe. Each word read out is written straight back at the tail, so the stored command stays intact and can be played again as often as needed. The occupancy count tells the sequencer how many pops make up one full pass.

A push into a full buffer never stalls and is never refused. The oldest word is discarded and the new word is appended. Pushing a full buffer's worth of new words therefore replaces the previous command completely. A four-bit clear control empties the buffer. Three sticky flags record misuse: a push while full, a pop while empty, and an inconsistent occupancy state. Only reset clears these flags.

Top module: `cmd_replay_buf`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, `full_o` is 0, `pop_data_o` is 0 and all three error flags are 0.
- R2: A push with no pop, no clear and `full_o` low appends `push_data_i` at the tail and raises `count_o` by one in the next cycle. Words come out in the order they were pushed.
- R3: While `empty_o` is low, `pop_data_o` shows the oldest stored word. A pop moves on to the next word and writes the popped word back at the tail, and `count_o` stays unchanged. After `count_o` pops the same sequence starts again.
- R4: A push while `full_o` is high discards the oldest word and appends the new one, and `count_o` stays at the capacity (13 by default). A run of capacity pushes replaces every stored word.
- R5: A push while `full_o` is high and the clear is inactive sets `err_wr_o` in the next cycle.
- R6: A pop while `empty_o` is high and the clear is inactive sets `err_rd_o` in the next cycle, and the pop changes nothing else.
- R7: The clear is inactive only while `clr_i` equals 4'b1001. The active code is 4'b0110, and any other value also acts as a clear. While the clear is active, the buffer empties at the next edge and push and pop strobes are ignored. Pushes are accepted again once `clr_i` returns to 4'b1001.
- R8: A push and a pop in the same cycle on a buffer that is neither empty nor full write the popped word back to the tail first and then append the pushed word. `count_o` rises by one.
- R9: A push and a pop in the same cycle on a full buffer write the popped word back to the tail. The new word then displaces the next-oldest word, `count_o` stays at the capacity, and `err_wr_o` is set.
- R10: `err_state_o` becomes set if the full and empty flags are both high or the occupancy exceeds the capacity. It stays 0 through every legal strobe sequence.
- R11: The error flags stay set until reset. The clear does not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 4 | Multi-bit clear: 4'b1001 inactive, anything else clears |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 32 | Word to push |
| pop_i | input | 1 | Pop (replay) strobe |
| pop_data_o | output | 32 | Oldest stored word, 0 when empty |
| count_o | output | 4 | Number of stored words |
| full_o | output | 1 | Buffer holds capacity words |
| empty_o | output | 1 | Buffer holds no words |
| err_wr_o | output | 1 | Sticky: push while full |
| err_rd_o | output | 1 | Sticky: pop while empty |
| err_state_o | output | 1 | Sticky: inconsistent occupancy state |

## Verification
Push and replay can fall in the same cycle, and this needs two storage writes at once. The bench provokes the collision on a partly filled buffer, on a buffer one word short of full, and on a full buffer. In each case it compares the occupancy, the head word and the following replay order with a word-queue model that recirculates first and appends second. It also provokes a push and a pop together on an empty buffer. There the read error must be flagged while the push still lands, which shows that the two strobes are judged independently.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  typedef logic [3:0] mbool4_t;
  localparam mbool4_t CLR_OFF = 4'b1001;
  localparam mbool4_t CLR_ON  = 4'b0110;

  localparam int ERR_NUM = 3;
  localparam int ERR_WR  = 0;
  localparam int ERR_RD  = 1;
  localparam int ERR_ST  = 2;
endpackage

// File: rtl/cmdbuf_store.sv
module cmdbuf_store #(
  parameter int DEPTH = 13,
  parameter int WIDTH = 32,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_a_i,
  input  logic [PTR_W-1:0] addr_a_i,
  input  logic [WIDTH-1:0] data_a_i,
  input  logic             we_b_i,
  input  logic [PTR_W-1:0] addr_b_i,
  input  logic [WIDTH-1:0] data_b_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic             hit_a, hit_b, en;
    logic [WIDTH-1:0] d;
    always_comb begin
      hit_a = we_a_i && (addr_a_i == PTR_W'(i));
      hit_b = we_b_i && (addr_b_i == PTR_W'(i));
      en    = hit_a || hit_b;
      d     = hit_b ? data_b_i : data_a_i;
    end
    always_ff @(posedge clk_i) begin
      if (en) mem_q[i] <= d;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl #(
  parameter int DEPTH = 13,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             we_a_o,
  output logic [PTR_W-1:0] addr_a_o,
  output logic             we_b_o,
  output logic [PTR_W-1:0] addr_b_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             wr_err_o,
  output logic             rd_err_o,
  output logic             st_err_o
);
  localparam logic [PTR_W:0] DEPTH_X = (PTR_W+1)'(DEPTH);

  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, full_d, empty_q, empty_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                           input logic [1:0] k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= DEPTH_X) s = s - DEPTH_X;
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    do_push = push_i && !clr_i;
    do_pop  = pop_i && !clr_i && !empty_q;

    we_a_o   = do_pop;
    addr_a_o = wptr_q;
    we_b_o   = do_push;
    addr_b_o = do_pop ? adv(wptr_q, 2'd1) : wptr_q;

    if (clr_i) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      rptr_d = adv(rptr_q, {1'b0, do_pop} + {1'b0, do_push && full_q});
      wptr_d = adv(wptr_q, {1'b0, do_pop} + {1'b0, do_push});
      cnt_d  = cnt_q + CNT_W'(do_push && !full_q);
    end
    full_d  = (cnt_d == CNT_W'(DEPTH));
    empty_d = (cnt_d == '0);

    wr_err_o = push_i && !clr_i && full_q;
    rd_err_o = pop_i && !clr_i && empty_q;
    st_err_o = (full_q && empty_q) || (cnt_q > CNT_W'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      rptr_q  <= rptr_d;
      wptr_q  <= wptr_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign rptr_o  = rptr_q;
  assign count_o = cnt_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/cmdbuf_errs.sv
module cmdbuf_errs #(
  parameter int NUM = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] pulse_i,
  output logic [NUM-1:0] sticky_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic q, d;
    always_comb d = q || pulse_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d;
    end
    assign sticky_o[i] = q;
  end
endmodule

// File: rtl/cmd_replay_buf.sv
module cmd_replay_buf
  import cmdbuf_pkg::*;
#(
  parameter int DEPTH = 13,
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_wr_o,
  output logic             err_rd_o,
  output logic             err_state_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             clr_act;
  logic             we_a, we_b;
  logic [PTR_W-1:0] addr_a, addr_b, rptr;
  logic [WIDTH-1:0] head;
  logic [ERR_NUM-1:0] err_pulse, err_flag;

  // Fail-safe decode: only the exact inactive code lets the buffer run.
  assign clr_act = (clr_i != CLR_OFF);

  cmdbuf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_act),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .we_a_o   (we_a),
    .addr_a_o (addr_a),
    .we_b_o   (we_b),
    .addr_b_o (addr_b),
    .rptr_o   (rptr),
    .count_o  (count_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .wr_err_o (err_pulse[ERR_WR]),
    .rd_err_o (err_pulse[ERR_RD]),
    .st_err_o (err_pulse[ERR_ST])
  );

  // Port A recirculates the head word, port B takes the pushed word.
  cmdbuf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_store (
    .clk_i    (clk_i),
    .we_a_i   (we_a),
    .addr_a_i (addr_a),
    .data_a_i (head),
    .we_b_i   (we_b),
    .addr_b_i (addr_b),
    .data_b_i (push_data_i),
    .raddr_i  (rptr),
    .rdata_o  (head)
  );

  cmdbuf_errs #(.NUM(ERR_NUM)) u_errs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (err_pulse),
    .sticky_o (err_flag)
  );

  assign pop_data_o  = empty_o ? '0 : head;
  assign err_wr_o    = err_flag[ERR_WR];
  assign err_rd_o    = err_flag[ERR_RD];
  assign err_state_o = err_flag[ERR_ST];
endmodule

// File: rtl/cmd_replay_buf_chk.sv
module cmd_replay_buf_chk
  import cmdbuf_pkg::*;
#(
  parameter int DEPTH = 13,
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       clr_i,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] pop_data_o,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             err_wr_o,
  input logic             err_rd_o,
  input logic             err_state_o
);
  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == CLR_OFF && push_i && !full_o) |=> count_o == $past(count_o) + 1'b1);

  a_r3_pop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == CLR_OFF && pop_i && !push_i && !empty_o) |=> $stable(count_o));

  a_r4_full_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == CLR_OFF && push_i && full_o) |=> full_o);

  a_r5_wr_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == CLR_OFF && push_i && full_o) |=> err_wr_o);

  a_r6_rd_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == CLR_OFF && pop_i && empty_o) |=> err_rd_o);

  a_r6_empty_output_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> pop_data_o == '0);

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != CLR_OFF) |=> (empty_o && count_o == '0 && !full_o));

  a_r10_no_state_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_state_o);

  a_r11_wr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_wr_o |=> err_wr_o);

  a_r11_rd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rd_o |=> err_rd_o);
endmodule

bind cmd_replay_buf cmd_replay_buf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .pop_data_o  (pop_data_o),
  .count_o     (count_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_wr_o    (err_wr_o),
  .err_rd_o    (err_rd_o),
  .err_state_o (err_state_o)
);

// File: tb/tb_cmd_replay_buf.sv
module tb_cmd_replay_buf;
  localparam int DEPTH = 13;
  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [3:0] OFF = 4'b1001;
  localparam logic [3:0] ON  = 4'b0110;
  localparam int NSTEP = 30;

  // {clr[37:34], push[33], pop[32], data[31:0]}
  localparam logic [37:0] STEPS [NSTEP] = '{
    {OFF, 1'b0, 1'b1, 32'h0},        {OFF, 1'b1, 1'b0, 32'hA000_0001},
    {OFF, 1'b1, 1'b0, 32'hA000_0002}, {OFF, 1'b1, 1'b0, 32'hA000_0003},
    {OFF, 1'b0, 1'b1, 32'h0},        {OFF, 1'b0, 1'b1, 32'h0},
    {OFF, 1'b0, 1'b1, 32'h0},        {OFF, 1'b1, 1'b1, 32'hB000_0001},
    {OFF, 1'b1, 1'b0, 32'hC000_0001}, {OFF, 1'b1, 1'b0, 32'hC000_0002},
    {OFF, 1'b1, 1'b0, 32'hC000_0003}, {OFF, 1'b1, 1'b0, 32'hC000_0004},
    {OFF, 1'b1, 1'b0, 32'hC000_0005}, {OFF, 1'b1, 1'b0, 32'hC000_0006},
    {OFF, 1'b1, 1'b0, 32'hC000_0007}, {OFF, 1'b1, 1'b0, 32'hC000_0008},
    {OFF, 1'b1, 1'b1, 32'hC000_0009}, {OFF, 1'b1, 1'b0, 32'hC000_000A},
    {OFF, 1'b1, 1'b0, 32'hC000_000B}, {OFF, 1'b1, 1'b0, 32'hC000_000C},
    {OFF, 1'b0, 1'b1, 32'h0},        {OFF, 1'b1, 1'b1, 32'hD000_0001},
    {OFF, 1'b1, 1'b0, 32'hD000_0002}, {OFF, 1'b0, 1'b1, 32'h0},
    {ON,  1'b1, 1'b1, 32'hE000_0001}, {OFF, 1'b1, 1'b0, 32'hE000_0002},
    {4'h0, 1'b1, 1'b0, 32'hE000_0003}, {OFF, 1'b1, 1'b1, 32'hE000_0004},
    {OFF, 1'b0, 1'b1, 32'h0},        {OFF, 1'b1, 1'b1, 32'hE000_0005}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [3:0]       clr_i;
  logic             push_i, pop_i;
  logic [WIDTH-1:0] push_data_i, pop_data_o;
  logic [CNT_W-1:0] count_o;
  logic             full_o, empty_o, err_wr_o, err_rd_o, err_state_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] mq[$];
  bit m_wr, m_rd;

  cmd_replay_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .push_i(push_i),
    .push_data_i(push_data_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
    .err_wr_o(err_wr_o), .err_rd_o(err_rd_o), .err_state_o(err_state_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic [3:0] c, input bit pu, input bit po,
                            input logic [31:0] d);
    logic [31:0] w;
    if (c != OFF) begin
      mq.delete();
    end else begin
      if (pu && mq.size() == DEPTH) m_wr = 1;
      if (po && mq.size() == 0) m_rd = 1;
      if (po && mq.size() != 0) begin
        w = mq.pop_front();
        mq.push_back(w);
      end
      if (pu) begin
        if (mq.size() == DEPTH) void'(mq.pop_front());
        mq.push_back(d);
      end
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count", 32'(count_o), 32'(mq.size()));
    chk(tag, "empty", 32'(empty_o), 32'(mq.size() == 0));
    chk(tag, "full",  32'(full_o),  32'(mq.size() == DEPTH));
    chk(tag, "head",  pop_data_o, (mq.size() == 0) ? 32'h0 : mq[0]);
    chk("R5", "err_wr", 32'(err_wr_o), 32'(m_wr));
    chk("R6", "err_rd", 32'(err_rd_o), 32'(m_rd));
    chk("R10", "err_state", 32'(err_state_o), 32'h0);
  endtask

  task automatic step(input logic [3:0] c, input bit pu, input bit po,
                      input logic [31:0] d, input string tag);
    @(negedge clk_i);
    clr_i = c; push_i = pu; pop_i = po; push_data_i = d;
    @(posedge clk_i);
    #1;
    clr_i = OFF; push_i = 0; pop_i = 0; push_data_i = '0;
    model_step(c, pu, po, d);
    compare_all(tag);
  endtask

  function automatic string tag_of(input logic [3:0] c, input bit pu, input bit po,
                                   input int sz);
    if (c != OFF) return "R7";
    if (pu && po) return (sz == DEPTH) ? "R9" : "R8";
    if (pu) return (sz == DEPTH) ? "R4" : "R2";
    if (po) return (sz == 0) ? "R6" : "R3";
    return "R1";
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    mq.delete(); m_wr = 0; m_rd = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; clr_i = OFF; push_i = 0; pop_i = 0; push_data_i = '0;
    m_wr = 0; m_rd = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    compare_all("R1");

    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i][37:34], STEPS[i][33], STEPS[i][32], STEPS[i][31:0],
           tag_of(STEPS[i][37:34], STEPS[i][33], STEPS[i][32], mq.size()));
    end

    // R4: a full load of new words replaces the old command entirely
    step(ON, 0, 0, 0, "R7");
    for (int i = 0; i < DEPTH; i++) step(OFF, 1, 0, 32'hF000_0000 + i, "R2");
    for (int i = 0; i < DEPTH; i++) step(OFF, 1, 0, 32'h6000_0000 + i, "R4");
    // R3: two full replay passes reproduce the same order
    for (int i = 0; i < 2 * DEPTH; i++) begin
      chk("R3", "replay word", pop_data_o, 32'h6000_0000 + (i % DEPTH));
      step(OFF, 0, 1, 0, "R3");
    end
    // R8: collision one word short of full
    step(ON, 0, 0, 0, "R7");
    for (int i = 0; i < DEPTH - 1; i++) step(OFF, 1, 0, 32'h7000_0000 + i, "R2");
    step(OFF, 1, 1, 32'h7700_0000, "R8");
    for (int i = 0; i < DEPTH; i++) step(OFF, 0, 1, 0, "R8");

    // R11: clear leaves errors; reset removes them
    step(ON, 0, 1, 0, "R7");
    chk("R11", "err_wr after clear", 32'(err_wr_o), 32'h1);
    chk("R11", "err_rd after clear", 32'(err_rd_o), 32'h1);
    do_reset();
    chk("R11", "err_wr after reset", 32'(err_wr_o), 32'h0);
    chk("R11", "err_rd after reset", 32'(err_rd_o), 32'h0);
    compare_all("R1");
    // R6: empty pop with simultaneous push still lands the push
    step(OFF, 1, 1, 32'h5555_AAAA, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule